// File: doc/BRIEF.md
# Data Alignment Fault Detector

This unit inspects every data memory reference issued by a load/store pipeline. It raises an alignment fault when the reference is not on the natural boundary of its data type and checking is switched on. Each request supplies the low bits of the effective address, a data-type code, an operand-size code, two software-controlled enable bits (one from a control register, one from the flags register) and the current privilege level.

The required boundary comes from the data type. For bit strings and floating-point save areas it also depends on the operand size. A reference is misaligned when any address bit below log2 of that boundary is set. A fault needs all of the following: the control enable bit is 1, the flags enable bit is 1, the privilege level is 3, and the reference is misaligned.

A detected fault produces a one-cycle registered pulse and a vector number of 17, with an error code of zero. The unit also captures the offending address bits, the data type and the instruction pointer of the faulting instruction. These are held for the exception logic until the next fault overwrites them.

Top module: `align_chk_unit`

## Requirements
- R1: A fault is raised only when both `cr_am_i` and `fl_ac_i` are 1. If either is 0, no request ever faults.
- R2: A fault is raised only when `cpl_i` is 3. Privilege levels 0, 1 and 2 never fault.
- R3: While `rst_ni` is low, and after its release until the first fault, `fault_o` is 0 and every captured output (`fault_vec_o`, `fault_addr_o`, `fault_type_o`, `fault_ip_o`) is 0.
- R4: Required boundary by `req_type_i` code:
  - 0 byte: 1
  - 1 word: 2
  - 2 doubleword: 4
  - 3 quadword: 8
  - 5 128-bit media: 16
  - 6 64-bit media: 8
  - 7 segment selector: 2
  - 8 32-bit near pointer: 4
  - 9 32-bit far pointer: 2
  - 10 48-bit far pointer: 4
  - 11 single float: 4
  - 12 double float: 8
  - 13 extended float: 8
  - 15 reserved: 1

  For all of these codes, `req_osz_i` is ignored.
- R5: Size-dependent types use `req_osz_i` (0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = reserved):
  - Code 4 (bit string) needs 2, 4, 8 and 8 bytes for sizes 0, 1, 2 and 3.
  - Code 14 (floating-point save area) needs 2 bytes for size 0 and 4 bytes otherwise.
- R6: A request is misaligned when any `req_addr_i` bit below log2(boundary) is 1. Byte-boundary types never fault, and a cycle with `req_valid_i` low never faults.
- R7: `fault_o` is 1 in exactly the cycle after a cycle that holds a valid, enabled, misaligned request, and is 0 otherwise.
- R8: On a fault `fault_vec_o` reads 17, and `fault_err_o` is always zero.
- R9: On a fault, `fault_addr_o`, `fault_type_o` and `fault_ip_o` take the request's address bits, type code and instruction pointer. They hold those values unchanged until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Data reference present this cycle |
| req_addr_i | input | ADDR_W | Low effective-address bits |
| req_type_i | input | 4 | Data-type code (R4, R5) |
| req_osz_i | input | 2 | Operand-size code for size-dependent types |
| req_ip_i | input | IP_W | Instruction pointer of the referencing instruction |
| cr_am_i | input | 1 | Control-register alignment-mask enable |
| fl_ac_i | input | 1 | Flags-register alignment-check enable |
| cpl_i | input | 2 | Current privilege level |
| fault_o | output | 1 | One-cycle alignment fault pulse |
| fault_vec_o | output | 8 | Fault vector number |
| fault_err_o | output | ERR_W | Error code (zero) |
| fault_addr_o | output | ADDR_W | Captured address bits of the last fault |
| fault_type_o | output | 4 | Captured data-type code of the last fault |
| fault_ip_o | output | IP_W | Captured instruction pointer of the last fault |

## Verification
The bench crosses every type and size entry with all sixteen enable/privilege combinations and all sixteen low-address offsets.

- A lookup with one wrong boundary would fault at offsets that are legal, or stay silent at illegal ones.
- A design that tested only one enable bit would fault with the other bit cleared.
- A design that compared privilege as "nonzero" would fault at levels 1 and 2.

Directed tests cover the remaining corners:
- Misaligned requests with the valid strobe low, which must not fault.
- Back-to-back faults, to catch a pulse that stretches or is lost.
- Aligned traffic after a fault, to catch captured fields that drift.
- A reset taken in the middle of the run, which must clear everything.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;

    localparam int unsigned TYPE_W = 4;
    localparam int unsigned OSZ_W  = 2;
    localparam int unsigned CPL_W  = 2;
    localparam int unsigned LG_W   = 3;
    localparam int unsigned VEC_W  = 8;

    localparam logic [VEC_W-1:0] ALIGN_VECTOR = 8'd17;
    localparam logic [CPL_W-1:0] USER_CPL     = 2'd3;

    typedef enum logic [TYPE_W-1:0] {
        DT_BYTE     = 4'd0,
        DT_WORD     = 4'd1,
        DT_DWORD    = 4'd2,
        DT_QWORD    = 4'd3,
        DT_BITSTR   = 4'd4,
        DT_VEC128   = 4'd5,
        DT_VEC64    = 4'd6,
        DT_SELECTOR = 4'd7,
        DT_NPTR32   = 4'd8,
        DT_FPTR32   = 4'd9,
        DT_FPTR48   = 4'd10,
        DT_FLT_SP   = 4'd11,
        DT_FLT_DP   = 4'd12,
        DT_FLT_EP   = 4'd13,
        DT_FSAVE    = 4'd14,
        DT_RSVD     = 4'd15
    } dtype_e;

    typedef enum logic [OSZ_W-1:0] {
        OSZ_16  = 2'd0,
        OSZ_32  = 2'd1,
        OSZ_64  = 2'd2,
        OSZ_RSV = 2'd3
    } osz_e;

endpackage

// File: rtl/align_bound_lut.sv
module align_bound_lut
    import align_chk_pkg::*;
(
    input  logic [TYPE_W-1:0] type_i,
    input  logic [OSZ_W-1:0]  osz_i,
    output logic [LG_W-1:0]   lg_o
);

    // log2 of the boundary for size-dependent bit strings
    logic [LG_W-1:0] lg_bitstr;
    // log2 of the boundary for floating-point save areas
    logic [LG_W-1:0] lg_fsave;

    always_comb begin
        unique case (osz_e'(osz_i))
            OSZ_16:  lg_bitstr = 3'd1;
            OSZ_32:  lg_bitstr = 3'd2;
            default: lg_bitstr = 3'd3;
        endcase
        lg_fsave = (osz_e'(osz_i) == OSZ_16) ? 3'd1 : 3'd2;
    end

    always_comb begin
        unique case (dtype_e'(type_i))
            DT_WORD, DT_SELECTOR, DT_FPTR32:             lg_o = 3'd1;
            DT_DWORD, DT_NPTR32, DT_FPTR48, DT_FLT_SP:   lg_o = 3'd2;
            DT_QWORD, DT_VEC64, DT_FLT_DP, DT_FLT_EP:    lg_o = 3'd3;
            DT_VEC128:                                   lg_o = 3'd4;
            DT_BITSTR:                                   lg_o = lg_bitstr;
            DT_FSAVE:                                    lg_o = lg_fsave;
            default:                                     lg_o = 3'd0;
        endcase
    end

endmodule

// File: rtl/align_misalign_det.sv
module align_misalign_det
    import align_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LG_W-1:0]   lg_i,
    output logic              mis_o
);

    logic [ADDR_W-1:0] below_mask;

    // bit i must be zero when i lies below log2(boundary)
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign below_mask[i] = (32'(lg_i) > i);
    end

    assign mis_o = |(addr_i & below_mask);

endmodule

// File: rtl/align_enable_gate.sv
module align_enable_gate
    import align_chk_pkg::*;
(
    input  logic             valid_i,
    input  logic             cr_am_i,
    input  logic             fl_ac_i,
    input  logic [CPL_W-1:0] cpl_i,
    output logic             chk_en_o
);

    logic both_bits;
    logic user_level;

    assign both_bits  = cr_am_i & fl_ac_i;
    assign user_level = (cpl_i == USER_CPL);
    assign chk_en_o   = valid_i & both_bits & user_level;

endmodule

// File: rtl/align_chk_unit.sv
module align_chk_unit
    import align_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IP_W   = 48,
    parameter int unsigned ERR_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_type_i,
    input  logic [1:0]        req_osz_i,
    input  logic [IP_W-1:0]   req_ip_i,
    input  logic              cr_am_i,
    input  logic              fl_ac_i,
    input  logic [1:0]        cpl_i,
    output logic              fault_o,
    output logic [7:0]        fault_vec_o,
    output logic [ERR_W-1:0]  fault_err_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic [3:0]        fault_type_o,
    output logic [IP_W-1:0]   fault_ip_o
);

    typedef struct packed {
        logic              fault;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] dtype;
        logic [IP_W-1:0]   ip;
    } rpt_t;

    logic [LG_W-1:0] lg;
    logic            mis;
    logic            chk_en;
    rpt_t            rpt_d;
    rpt_t            rpt_q;

    align_bound_lut i_lut (
        .type_i (req_type_i),
        .osz_i  (req_osz_i),
        .lg_o   (lg)
    );

    align_misalign_det #(.ADDR_W(ADDR_W)) i_det (
        .addr_i (req_addr_i),
        .lg_i   (lg),
        .mis_o  (mis)
    );

    align_enable_gate i_gate (
        .valid_i  (req_valid_i),
        .cr_am_i  (cr_am_i),
        .fl_ac_i  (fl_ac_i),
        .cpl_i    (cpl_i),
        .chk_en_o (chk_en)
    );

    always_comb begin
        rpt_d       = rpt_q;
        rpt_d.fault = 1'b0;
        if (chk_en && mis) begin
            rpt_d.fault = 1'b1;
            rpt_d.vec   = ALIGN_VECTOR;
            rpt_d.addr  = req_addr_i;
            rpt_d.dtype = req_type_i;
            rpt_d.ip    = req_ip_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rpt_q <= '0;
        end else begin
            rpt_q <= rpt_d;
        end
    end

    assign fault_o      = rpt_q.fault;
    assign fault_vec_o  = rpt_q.vec;
    assign fault_err_o  = '0;
    assign fault_addr_o = rpt_q.addr;
    assign fault_type_o = rpt_q.dtype;
    assign fault_ip_o   = rpt_q.ip;

endmodule

// File: rtl/align_chk_sva.sv
module align_chk_sva #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IP_W   = 48
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [3:0]        req_type_i,
    input logic              cr_am_i,
    input logic              fl_ac_i,
    input logic [1:0]        cpl_i,
    input logic              fault_o,
    input logic [7:0]        fault_vec_o,
    input logic [ADDR_W-1:0] fault_addr_o,
    input logic [3:0]        fault_type_o,
    input logic [IP_W-1:0]   fault_ip_o
);

    AST_FAULT_BOTH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(cr_am_i && fl_ac_i)); // R1

    AST_FAULT_USER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(cpl_i) == 2'd3); // R2

    AST_NO_BYTE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> ($past(req_type_i) != 4'd0 && $past(req_type_i) != 4'd15)); // R6

    AST_FAULT_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(req_valid_i)); // R7

    AST_FAULT_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> fault_vec_o == 8'd17); // R8

    AST_TYPE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> fault_type_o == $past(req_type_i)); // R9

    AST_HOLD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o |-> ($stable(fault_addr_o) && $stable(fault_type_o) && $stable(fault_ip_o))); // R9

endmodule

bind align_chk_unit align_chk_sva #(.ADDR_W(ADDR_W), .IP_W(IP_W)) i_align_chk_sva (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_type_i   (req_type_i),
    .cr_am_i      (cr_am_i),
    .fl_ac_i      (fl_ac_i),
    .cpl_i        (cpl_i),
    .fault_o      (fault_o),
    .fault_vec_o  (fault_vec_o),
    .fault_addr_o (fault_addr_o),
    .fault_type_o (fault_type_o),
    .fault_ip_o   (fault_ip_o)
);

// File: tb/test_align_chk_unit.sv
`timescale 1ns/1ps
module test_align_chk_unit;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned IP_W   = 48;
    localparam int unsigned ERR_W  = 32;
    localparam int unsigned NVEC   = 21;

    // {type code, size code, log2 boundary}
    localparam logic [8:0] VEC_TBL [NVEC] = '{
        {4'd0,  2'd2, 3'd0}, {4'd1,  2'd0, 3'd1}, {4'd2,  2'd3, 3'd2},
        {4'd3,  2'd0, 3'd3}, {4'd4,  2'd0, 3'd1}, {4'd4,  2'd1, 3'd2},
        {4'd4,  2'd2, 3'd3}, {4'd4,  2'd3, 3'd3}, {4'd5,  2'd0, 3'd4},
        {4'd6,  2'd1, 3'd3}, {4'd7,  2'd2, 3'd1}, {4'd8,  2'd0, 3'd2},
        {4'd9,  2'd3, 3'd1}, {4'd10, 2'd0, 3'd2}, {4'd11, 2'd1, 3'd2},
        {4'd12, 2'd0, 3'd3}, {4'd13, 2'd2, 3'd3}, {4'd14, 2'd0, 3'd1},
        {4'd14, 2'd1, 3'd2}, {4'd14, 2'd2, 3'd2}, {4'd15, 2'd1, 3'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        dtype = '0;
    logic [1:0]        osz = '0;
    logic [IP_W-1:0]   ip = '0;
    logic              am = 1'b0;
    logic              ac = 1'b0;
    logic [1:0]        cpl = '0;
    logic              fault;
    logic [7:0]        vec;
    logic [ERR_W-1:0]  err;
    logic [ADDR_W-1:0] f_addr;
    logic [3:0]        f_type;
    logic [IP_W-1:0]   f_ip;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [ADDR_W-1:0] m_addr = '0;
    logic [3:0]        m_type = '0;
    logic [IP_W-1:0]   m_ip   = '0;

    always #2.5 clk = ~clk;

    align_chk_unit #(.ADDR_W(ADDR_W), .IP_W(IP_W), .ERR_W(ERR_W)) i_align_chk_unit (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
        .req_type_i(dtype), .req_osz_i(osz), .req_ip_i(ip), .cr_am_i(am),
        .fl_ac_i(ac), .cpl_i(cpl), .fault_o(fault), .fault_vec_o(vec),
        .fault_err_o(err), .fault_addr_o(f_addr), .fault_type_o(f_type),
        .fault_ip_o(f_ip)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample just after the next rising edge
    task automatic issue(input logic v, input logic [3:0] t, input logic [1:0] s,
                         input logic [ADDR_W-1:0] a, input logic e_am, input logic e_ac,
                         input logic [1:0] pl, input logic [IP_W-1:0] p);
        @(negedge clk);
        valid = v; dtype = t; osz = s; addr = a; am = e_am; ac = e_ac; cpl = pl; ip = p;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_outputs(input string tag, input logic exp_fault);
        chk({tag, " fault"}, 64'(fault), 64'(exp_fault));
        chk("R8 err", 64'(err), 64'd0);
        chk({tag, " addr"}, 64'(f_addr), 64'(m_addr));
        chk({tag, " type"}, 64'(f_type), 64'(m_type));
        chk({tag, " ip"}, 64'(f_ip), 64'(m_ip));
    endtask

    initial begin
        // R3: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R3 fault in reset", 64'(fault), 64'd0);
        chk("R3 vec in reset", 64'(vec), 64'd0);
        chk("R3 addr in reset", 64'(f_addr), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(1'b1, 4'd2, 2'd0, 4'd4, 1'b1, 1'b1, 2'd3, 48'h1);
        chk("R3 after release", 64'(fault), 64'd0);
        chk("R3 ip after release", 64'(f_ip), 64'd0);

        // sweep: every entry, every enable/privilege combination, every offset
        for (int v = 0; v < NVEC; v++) begin
            for (int c = 0; c < 16; c++) begin
                for (int off = 0; off < 16; off++) begin
                    logic [3:0] t;
                    logic [1:0] s;
                    logic [2:0] lg;
                    logic       e_am, e_ac, mis, exp_f;
                    logic [1:0] pl;
                    logic [IP_W-1:0] p;
                    string tag;
                    {t, s, lg} = VEC_TBL[v];
                    e_am = c[3]; e_ac = c[2]; pl = c[1:0];
                    mis = ((off & ((1 << lg) - 1)) != 0);
                    exp_f = e_am && e_ac && (pl == 2'd3) && mis;
                    p = IP_W'((v << 12) | (c << 4) | off) + 48'h4000_0000;
                    if (!(e_am && e_ac))          tag = "R1";
                    else if (pl != 2'd3)          tag = "R2";
                    else if (lg == 3'd0)          tag = "R6";
                    else if (t == 4'd4 || t == 4'd14) tag = "R5";
                    else                          tag = "R4";
                    issue(1'b1, t, s, ADDR_W'(off), e_am, e_ac, pl, p);
                    if (exp_f) begin
                        m_addr = ADDR_W'(off); m_type = t; m_ip = p;
                        chk("R8 vector", 64'(vec), 64'd17);
                    end
                    chk_outputs(tag, exp_f);
                end
            end
        end

        // R6: valid low with a misaligned, fully enabled request
        issue(1'b0, 4'd5, 2'd0, 4'd3, 1'b1, 1'b1, 2'd3, 48'hdead);
        chk_outputs("R6 valid low", 1'b0);

        // R7: single fault then idle cycle -> one-cycle pulse
        issue(1'b1, 4'd1, 2'd0, 4'd1, 1'b1, 1'b1, 2'd3, 48'hAA);
        m_addr = 4'd1; m_type = 4'd1; m_ip = 48'hAA;
        chk_outputs("R7 pulse high", 1'b1);
        issue(1'b0, 4'd1, 2'd0, 4'd1, 1'b1, 1'b1, 2'd3, 48'hBB);
        chk_outputs("R7 pulse low", 1'b0);

        // R7/R9: back-to-back faults each captured
        issue(1'b1, 4'd3, 2'd0, 4'd6, 1'b1, 1'b1, 2'd3, 48'hC1);
        m_addr = 4'd6; m_type = 4'd3; m_ip = 48'hC1;
        chk_outputs("R7 first of pair", 1'b1);
        issue(1'b1, 4'd5, 2'd0, 4'd8, 1'b1, 1'b1, 2'd3, 48'hC2);
        m_addr = 4'd8; m_type = 4'd5; m_ip = 48'hC2;
        chk_outputs("R9 second of pair", 1'b1);

        // R9: aligned traffic leaves captured fields untouched
        issue(1'b1, 4'd5, 2'd0, 4'd0, 1'b1, 1'b1, 2'd3, 48'hD0);
        chk_outputs("R9 hold aligned", 1'b0);
        issue(1'b1, 4'd1, 2'd0, 4'd1, 1'b0, 1'b1, 2'd3, 48'hD1);
        chk_outputs("R9 hold disabled", 1'b0);

        // R3: reset in the middle of the run clears captured state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_addr = '0; m_type = '0; m_ip = '0;
        chk_outputs("R3 mid reset", 1'b0);
        chk("R3 vec mid reset", 64'(vec), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule